// File: doc/BRIEF.md
# Transactional First-Write Undo Log

This block sits beside one bank of a memory shared by several cores. It keeps the old contents of words that a core overwrites while that core is inside a hardware transaction, so the bank can be put back if the transaction has to be abandoned. Every core has its own fixed-size region in the log. Only the first store to a given word within a transaction costs a log entry. Repeated stores to that word go straight to the bank.

Core stores reach the bank through the block. For each store, the environment supplies the word the bank currently holds at the store address, and the block forwards the store on its bank write port. A commit strobe empties the core's region, which makes its stores final. An abort strobe queues a rollback. The block then walks that core's region from the newest entry to the oldest and writes one saved word back per cycle. It signals `busy` while the rollback runs and pulses `done` when the rollback ends. Every bank runs its own rollback and waits on no other bank. A first store that finds its core's region full is refused, flagged, and forces an abort.

Top module: `ulog_bank`

## Requirements
- R1: Coming out of reset, `busy`, `done`, `bk_we` and every bit of `ovf` are 0, and no core is in a transaction.
- R2: A store from a core that is not in a transaction appears on the bank port in the same cycle, with `bk_we`=1, `bk_addr`=`cw_addr` and `bk_data`=`cw_data`. It is never logged, so a later rollback leaves it in place.
- R3: The first store a transacting core makes to an address is forwarded to the bank in the same cycle, and the `cw_old` word is saved in that core's region.
- R4: Later stores to an address that is already logged in the current transaction add no entry. A rollback therefore makes exactly one bank write per distinct address and restores the value from before the first store.
- R5: A commit strobe ends the transaction and discards the core's entries. Committed data stays in the bank, and a later rollback restores only entries made after the next begin.
- R6: After an abort strobe, `busy` rises at the second clock edge. The saved words are written back one per cycle, newest entry first. `done` is high for one cycle with `done_core` naming the core, and only after the last write. `busy` falls at the next edge.
- R7: Each core's region holds LOG_DEPTH entries. A first store that finds the region full raises `ovf` for that core (one bit, in that cycle only), is not forwarded (`bk_we`=0), and forces a rollback of that core's region.
- R8: Regions are private. Rolling back one core neither writes the other core's addresses nor removes the other core's entries.
- R9: While `busy` is high, core stores are dropped. They are neither forwarded nor logged.
- R10: When rollbacks for several cores are pending, they run one after another, lowest core index first.
- R11: An abort with an empty region makes no bank write and raises `done` on the first `busy` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | NUM_CORES | Per-core transaction start strobe |
| tx_commit | input | NUM_CORES | Per-core commit strobe |
| tx_abort | input | NUM_CORES | Per-core abort strobe |
| cw_valid | input | 1 | Core store request |
| cw_core | input | CORE_W | Index of the storing core |
| cw_addr | input | ADDR_W | Store word address |
| cw_data | input | DATA_W | Store data |
| cw_old | input | DATA_W | Bank word currently held at `cw_addr` |
| bk_we | output | 1 | Bank write enable |
| bk_addr | output | ADDR_W | Bank write address |
| bk_data | output | DATA_W | Bank write data |
| busy | output | 1 | Rollback in progress |
| done | output | 1 | Rollback finished (one cycle) |
| done_core | output | CORE_W | Core whose rollback finished |
| ovf | output | NUM_CORES | Per-core region-full pulse |

## Verification
The hardest states to reach from the ports are a full region that meets a new address, and a store that arrives while another core's rollback is holding the bank port. The bench reaches both deliberately. It fills one core's region with distinct addresses and then stores to a fifth address. It also drives a non-transactional store from the other core on the first `busy` cycle after an abort. A sweep over every log fill level from 0 to LOG_DEPTH, for both cores, with every address stored twice, checks the newest-first write-back order and the one-entry-per-address rule against an array model of the bank kept in the bench.

// File: rtl/ulog_pkg.sv
package ulog_pkg;

    typedef enum logic {
        RB_IDLE = 1'b0,
        RB_RUN  = 1'b1
    } rb_state_e;

endpackage

// File: rtl/ulog_pick.sv
module ulog_pick #(
    parameter int NUM_REQ = 2,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REQ-1:0]  req,
    output logic                any,
    output logic [IDX_W-1:0]    idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (req[idx] && ((req & ((NUM_REQ'(1) << idx) - NUM_REQ'(1))) == '0))); // R10

endmodule

// File: rtl/ulog_region.sv
module ulog_region #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [DATA_W-1:0] push_data,
    output logic              hit,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] top_addr,
    output logic [DATA_W-1:0] top_data
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
        logic [CNT_W-1:0] cnt;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        full     = (r_q.cnt == CNT_W'(DEPTH));
        empty    = (r_q.cnt == '0);
        hit      = 1'b0;
        top_addr = '0;
        top_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if ((CNT_W'(i) < r_q.cnt) && (r_q.ent[i].addr == lk_addr)) hit = 1'b1;
            if (CNT_W'(i + 1) == r_q.cnt) begin
                top_addr = r_q.ent[i].addr;
                top_data = r_q.ent[i].data;
            end
        end

        r_d = r_q;
        if (clr) begin
            r_d.cnt = '0;
        end else if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(i) == r_q.cnt) begin
                    r_d.ent[i].addr = lk_addr;
                    r_d.ent[i].data = push_data;
                end
            end
            r_d.cnt = r_q.cnt + CNT_W'(1);
        end else if (pop && !empty) begin
            r_d.cnt = r_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= CNT_W'(DEPTH)); // R7
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !clr) |=> (r_q.cnt == $past(r_q.cnt) + CNT_W'(1))); // R3
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !clr && !push) |=> (r_q.cnt == $past(r_q.cnt) - CNT_W'(1))); // R6

endmodule

// File: rtl/ulog_bank.sv
module ulog_bank
    import ulog_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int LOG_DEPTH = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_CORES-1:0] tx_begin,
    input  logic [NUM_CORES-1:0] tx_commit,
    input  logic [NUM_CORES-1:0] tx_abort,
    input  logic                 cw_valid,
    input  logic [CORE_W-1:0]    cw_core,
    input  logic [ADDR_W-1:0]    cw_addr,
    input  logic [DATA_W-1:0]    cw_data,
    input  logic [DATA_W-1:0]    cw_old,
    output logic                 bk_we,
    output logic [ADDR_W-1:0]    bk_addr,
    output logic [DATA_W-1:0]    bk_data,
    output logic                 busy,
    output logic                 done,
    output logic [CORE_W-1:0]    done_core,
    output logic [NUM_CORES-1:0] ovf
);

    typedef struct packed {
        logic [NUM_CORES-1:0] in_tx;
        logic [NUM_CORES-1:0] pend;
        rb_state_e            st;
        logic [CORE_W-1:0]    rc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NUM_CORES-1:0] push, pop, clr, hit, full, empty;
    logic [NUM_CORES-1:0] beg_eff, cmt_eff, abt_eff;
    logic [ADDR_W-1:0]    top_a [NUM_CORES];
    logic [DATA_W-1:0]    top_d [NUM_CORES];
    logic                 pick_any;
    logic [CORE_W-1:0]    pick_idx;
    logic                 run_q;

    assign run_q = (ctl_q.st == RB_RUN);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_region
        ulog_region #(
            .DEPTH  (LOG_DEPTH),
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_region (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr[c]),
            .push      (push[c]),
            .pop       (pop[c]),
            .lk_addr   (cw_addr),
            .push_data (cw_old),
            .hit       (hit[c]),
            .full      (full[c]),
            .empty     (empty[c]),
            .top_addr  (top_a[c]),
            .top_data  (top_d[c])
        );
    end

    ulog_pick #(.NUM_REQ(NUM_CORES)) u_pick (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (ctl_q.pend),
        .any   (pick_any),
        .idx   (pick_idx)
    );

    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            logic own;
            own     = cw_valid && !run_q && (cw_core == CORE_W'(c)) && ctl_q.in_tx[c];
            push[c] = own && !hit[c] && !full[c];
            ovf[c]  = own && !hit[c] && full[c];
            pop[c]  = run_q && (ctl_q.rc == CORE_W'(c)) && !empty[c];
        end

        beg_eff = tx_begin & ~ctl_q.in_tx & ~ctl_q.pend;
        cmt_eff = tx_commit & ctl_q.in_tx;
        abt_eff = (tx_abort & ctl_q.in_tx) | ovf;
        clr     = beg_eff | cmt_eff;

        busy      = run_q;
        done      = run_q && empty[ctl_q.rc];
        done_core = ctl_q.rc;

        if (run_q) begin
            bk_we   = !empty[ctl_q.rc];
            bk_addr = top_a[ctl_q.rc];
            bk_data = top_d[ctl_q.rc];
        end else begin
            bk_we   = cw_valid && (ovf == '0);
            bk_addr = cw_addr;
            bk_data = cw_data;
        end

        ctl_d       = ctl_q;
        ctl_d.in_tx = (ctl_q.in_tx | beg_eff) & ~cmt_eff & ~abt_eff;
        ctl_d.pend  = ctl_q.pend | abt_eff;
        if (done) begin
            ctl_d.pend[ctl_q.rc] = 1'b0;
            ctl_d.st             = RB_IDLE;
        end else if (!run_q && pick_any) begin
            ctl_d.st = RB_RUN;
            ctl_d.rc = pick_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.in_tx <= '0;
            ctl_q.pend  <= '0;
            ctl_q.st    <= RB_IDLE;
            ctl_q.rc    <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R6
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R6
    AST_OVF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ovf)); // R7
    AST_OVF_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf != '0) |-> !bk_we); // R7
    AST_OVF_QUEUES: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf != '0) |=> (ctl_q.pend != '0)); // R7
    AST_BYPASS_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && !busy && (ovf == '0)) |-> (bk_we && bk_addr == cw_addr && bk_data == cw_data)); // R2
    AST_BUSY_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bk_we) |-> !done); // R9

endmodule

// File: tb/ulog_bank_tb.sv
module ulog_bank_tb;

    localparam int NC = 2;
    localparam int DP = 4;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NW = 1 << AW;
    localparam time CLK_P = 20ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0] tx_begin = '0, tx_commit = '0, tx_abort = '0;
    logic cw_valid = 1'b0;
    logic [0:0] cw_core = '0;
    logic [AW-1:0] cw_addr = '0;
    logic [DW-1:0] cw_data = '0;
    logic [DW-1:0] cw_old;
    logic bk_we, busy, done;
    logic [AW-1:0] bk_addr;
    logic [DW-1:0] bk_data;
    logic [0:0] done_core;
    logic [NC-1:0] ovf;

    logic [DW-1:0] mem [NW];
    logic [DW-1:0] expm [NW];
    logic [AW-1:0] seq [16];
    int seq_n;
    int errors = 0, checks = 0;

    logic s_we;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_data;
    logic [NC-1:0] s_ovf;
    int cyc;

    always #(CLK_P / 2) clk = ~clk;

    ulog_bank #(.NUM_CORES(NC), .LOG_DEPTH(DP), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin), .tx_commit(tx_commit),
        .tx_abort(tx_abort), .cw_valid(cw_valid), .cw_core(cw_core),
        .cw_addr(cw_addr), .cw_data(cw_data), .cw_old(cw_old),
        .bk_we(bk_we), .bk_addr(bk_addr), .bk_data(bk_data), .busy(busy),
        .done(done), .done_core(done_core), .ovf(ovf)
    );

    assign cw_old = mem[cw_addr];

    always @(posedge clk) begin
        if (rst_n && bk_we) mem[bk_addr] <= bk_data;
        if (rst_n && busy && bk_we && seq_n < 16) begin
            seq[seq_n] = bk_addr;
            seq_n = seq_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_mem(input string req);
        int bad = 0;
        for (int a = 0; a < NW; a++) if (mem[a] !== expm[a]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic wr(input int c, input int a, input int d);
        cw_valid = 1'b1;
        cw_core  = 1'(c);
        cw_addr  = AW'(a);
        cw_data  = DW'(d);
        #1;
        s_we = bk_we; s_addr = bk_addr; s_data = bk_data; s_ovf = ovf;
        @(negedge clk);
        cw_valid = 1'b0;
    endtask

    task automatic strobe(input int kind, input logic [NC-1:0] m);
        if (kind == 0) tx_begin = m;
        else if (kind == 1) tx_commit = m;
        else tx_abort = m;
        @(negedge clk);
        tx_begin = '0; tx_commit = '0; tx_abort = '0;
    endtask

    task automatic wait_done();
        cyc = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (done || cyc > 60) break;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < NW; a++) begin
            mem[a]  = DW'(a * 7 + 3);
            expm[a] = DW'(a * 7 + 3);
        end
        seq_n = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !done && !bk_we && ovf == '0, "R1", {busy, done, bk_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !bk_we && ovf == '0, "R1", {busy, done, bk_we}, 0);

        // R2 and R11: bypass store, then empty-log abort
        wr(1, 5, 8'h5A);
        chk(s_we && s_addr == 5 && s_data == 8'h5A, "R2", s_data, 8'h5A);
        expm[5] = 8'h5A;
        strobe(0, 2'b10);
        seq_n = 0;
        strobe(2, 2'b10);
        wait_done();
        chk(cyc == 1 && done_core == 1, "R11", cyc, 1);
        chk(seq_n == 0, "R11", seq_n, 0);
        @(negedge clk);
        chk_mem("R2");

        // sweep fill levels for both cores, each address stored twice
        for (int c = 0; c < NC; c++) begin
            for (int n = 0; n <= DP; n++) begin
                strobe(0, NC'(1 << c));
                for (int i = 0; i < n; i++) begin
                    wr(c, c * 8 + i * 2, 8'h80 + c * 16 + i);
                    chk(s_we && s_addr == AW'(c * 8 + i * 2), "R3", s_addr, c * 8 + i * 2);
                end
                for (int i = 0; i < n; i++) wr(c, c * 8 + i * 2, 8'h40 + i);
                seq_n = 0;
                strobe(2, NC'(1 << c));
                wait_done();
                chk(cyc == n + 1, "R6", cyc, n + 1);
                chk(done_core == 1'(c), "R6", done_core, c);
                chk(seq_n == n, "R4", seq_n, n);
                for (int k = 0; k < n; k++)
                    chk(seq[k] == AW'(c * 8 + (n - 1 - k) * 2), "R6", seq[k], c * 8 + (n - 1 - k) * 2);
                @(negedge clk);
                chk(!busy, "R6", busy, 0);
                chk_mem("R4");
            end
        end

        // R5: commit keeps data, next abort restores only new entries
        strobe(0, 2'b01);
        wr(0, 1, 8'h11);
        wr(0, 3, 8'h33);
        strobe(1, 2'b01);
        expm[1] = 8'h11; expm[3] = 8'h33;
        chk_mem("R5");
        strobe(0, 2'b01);
        wr(0, 1, 8'h99);
        seq_n = 0;
        strobe(2, 2'b01);
        wait_done();
        @(negedge clk);
        chk(seq_n == 1, "R5", seq_n, 1);
        chk_mem("R5");

        // R8: rollback of core 0 leaves core 1 alone
        strobe(0, 2'b11);
        wr(0, 7, 8'hA7);
        wr(1, 9, 8'hB9);
        strobe(2, 2'b01);
        wait_done();
        @(negedge clk);
        chk(mem[9] == 8'hB9, "R8", mem[9], 8'hB9);
        strobe(1, 2'b10);
        expm[9] = 8'hB9;
        chk_mem("R8");

        // R10: both abort together, lowest index served first
        strobe(0, 2'b11);
        wr(1, 11, 8'hC1);
        wr(0, 13, 8'hC0);
        strobe(2, 2'b11);
        wait_done();
        chk(done_core == 0, "R10", done_core, 0);
        wait_done();
        chk(done_core == 1, "R10", done_core, 1);
        @(negedge clk);
        chk_mem("R10");

        // R7: fill core 1 region, fifth distinct address overflows
        strobe(0, 2'b10);
        for (int i = 0; i < DP; i++) wr(1, i * 2, 8'hD0 + i);
        wr(1, 12, 8'hEE);
        chk(s_ovf == 2'b10, "R7", s_ovf, 2);
        chk(!s_we, "R7", s_we, 0);
        seq_n = 0;
        wait_done();
        chk(done_core == 1 && seq_n == DP, "R7", seq_n, DP);
        @(negedge clk);
        chk_mem("R7");

        // R9: store during rollback is dropped
        strobe(0, 2'b01);
        for (int i = 0; i < 3; i++) wr(0, i * 2 + 2, 8'h70 + i);
        strobe(2, 2'b01);
        @(negedge clk);
        chk(busy, "R9", busy, 1);
        wr(1, 15, 8'hEF);
        wait_done();
        @(negedge clk);
        chk(mem[15] == expm[15], "R9", mem[15], expm[15]);
        chk_mem("R9");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule